// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a shared word memory split into four equal banks, reached from two independent ports called left and right. Each bank belongs to exactly one port at a time. The owner is chosen by a per-bank select input, so two processors can hand blocks of data to each other by flipping a select line instead of copying the data. A port reaches only the banks it currently owns. Because no bank ever has two owners, the two ports never collide and no arbitration is needed.

Each port has an in-bank word address, a bank number, per-byte lane enables and a write strobe. It also has two chip enables of opposite polarity, which allow depth expansion, and an output enable. Everything runs on one clock. Writes land on the rising edge. Read data comes from the bank RAM's own output register one cycle after the request. The bank depth is a parameter, so simulation can use a small array while the real block is built with a large one.

Top module: `bank_dpram`

## Requirements
- R1: A write to an owned bank updates only the enabled byte lanes. `be[1]` covers bits 15:8 and `be[0]` covers bits 7:0. A write with both lanes disabled changes nothing.
- R2: A read presents data on `rdata` in the cycle after the request. Bits of a lane whose enable was low in the request read as zero.
- R3: A port is active only while `ce0_n` is 0 and `ce1` is 1. An inactive port writes nothing, returns zero data and raises no error.
- R4: `bank_sel[b]` = 0 gives bank b to the left port and 1 gives it to the right port. A change is sampled at a clock edge, so a request presented in the same cycle as the change still runs under the previous owner.
- R5: A write to a bank the port does not own is discarded.
- R6: An active access (read or write) to a bank the port does not own returns zero data and raises that port's `err` for exactly the following cycle.
- R7: While `oe_n` is 1, that port's `rdata` is zero. Lowering `oe_n` shows the pending read word in the same cycle.
- R8: The two ports work in the same cycle on different banks without affecting each other.
- R9: Reset is synchronous and active high. While it is asserted, accesses are ignored. After it, both ports show zero data and no error.
- R10: `ba` selects the bank. The same in-bank address in different banks holds independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | NBANK | Per-bank owner: 0 left, 1 right |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_be | input | DW/8 | Left byte-lane enables |
| l_ba | input | log2(NBANK) | Left bank number |
| l_addr | input | AW | Left in-bank word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data |
| l_err | output | 1 | Left unowned-access pulse |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_be | input | DW/8 | Right byte-lane enables |
| r_ba | input | log2(NBANK) | Right bank number |
| r_addr | input | AW | Right in-bank word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data |
| r_err | output | 1 | Right unowned-access pulse |

## Verification
A request presented in cycle t is captured at the following rising edge. Its read word and its error flag are therefore due in the cycle after that edge, and the bench samples them at the next falling edge before driving the next request. An ownership change follows the same rule: the bench flips a select line together with a request and expects that request to run under the previous owner, with the new owner applying from the next request. Output enable is combinational on the read path, so its effect is checked within a single cycle, once with `oe_n` high and once with it low.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int LANE_W = 8;
endpackage

// File: rtl/bdp_port_dec.sv
module bdp_port_dec #(
  parameter int NB   = 4,
  parameter int BW   = 2,
  parameter bit IS_R = 1'b0
) (
  input  logic          rst,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          wr,
  input  logic [BW-1:0] ba,
  input  logic [NB-1:0] own,
  output logic [NB-1:0] hit,
  output logic          rd_ok,
  output logic          err_now
);
  logic act;
  logic owned;

  assign act     = !rst && !ce0_n && ce1;
  assign owned   = (own[ba] == IS_R);
  assign rd_ok   = act && owned && !wr;
  assign err_now = act && !owned;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_hit
      assign hit[b] = act && owned && (ba == BW'(b));
    end
  endgenerate
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          own,
  input  logic          l_hit,
  input  logic          l_wr,
  input  logic [NL-1:0] l_be,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wd,
  input  logic          r_hit,
  input  logic          r_wr,
  input  logic [NL-1:0] r_be,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wd,
  output logic [DW-1:0] q
);
  import bdp_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          en;
  logic          wr;
  logic [NL-1:0] be;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;

  always_comb begin
    if (own == SIDE_R) begin
      en = r_hit; wr = r_wr; be = r_be; addr = r_addr; wd = r_wd;
    end else begin
      en = l_hit; wr = l_wr; be = l_be; addr = l_addr; wd = l_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (wr) begin
        for (int i = 0; i < NL; i++) begin
          if (be[i]) mem[addr][i*LANE_W +: LANE_W] <= wd[i*LANE_W +: LANE_W];
        end
      end else begin
        q <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/bdp_rdport.sv
module bdp_rdport #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_ok,
  input  logic          err_now,
  input  logic [BW-1:0] ba,
  input  logic [NL-1:0] be,
  input  logic          oe_n,
  input  logic [DW-1:0] bank_q [NB],
  output logic [DW-1:0] rdata,
  output logic          err
);
  import bdp_pkg::*;

  logic          vld_q;
  logic [BW-1:0] sel_q;
  logic [NL-1:0] be_q;
  logic [DW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      err   <= 1'b0;
      sel_q <= '0;
      be_q  <= '0;
    end else begin
      vld_q <= rd_ok;
      err   <= err_now;
      sel_q <= ba;
      be_q  <= be;
    end
  end

  generate
    for (genvar i = 0; i < NL; i++) begin : g_mask
      assign mask[i*LANE_W +: LANE_W] = {LANE_W{be_q[i]}};
    end
  endgenerate

  assign rdata = (!oe_n && vld_q) ? (bank_q[sel_q] & mask) : '0;
endmodule

// File: rtl/bank_dpram.sv
module bank_dpram #(
  parameter int NBANK = 4,
  parameter int AW    = 6,
  parameter int DW    = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int NL   = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] bank_sel,
  input  logic             l_ce0_n,
  input  logic             l_ce1,
  input  logic             l_wr,
  input  logic             l_oe_n,
  input  logic [NL-1:0]    l_be,
  input  logic [BW-1:0]    l_ba,
  input  logic [AW-1:0]    l_addr,
  input  logic [DW-1:0]    l_wdata,
  output logic [DW-1:0]    l_rdata,
  output logic             l_err,
  input  logic             r_ce0_n,
  input  logic             r_ce1,
  input  logic             r_wr,
  input  logic             r_oe_n,
  input  logic [NL-1:0]    r_be,
  input  logic [BW-1:0]    r_ba,
  input  logic [AW-1:0]    r_addr,
  input  logic [DW-1:0]    r_wdata,
  output logic [DW-1:0]    r_rdata,
  output logic             r_err
);
  logic [NBANK-1:0] own_q;
  logic [NBANK-1:0] l_hit, r_hit;
  logic             l_rd_ok, r_rd_ok;
  logic             l_err_now, r_err_now;
  logic [DW-1:0]    bank_q [NBANK];

  always_ff @(posedge clk) own_q <= bank_sel;

  bdp_port_dec #(.NB(NBANK), .BW(BW), .IS_R(1'b0)) u_dec_l (
    .rst(rst), .ce0_n(l_ce0_n), .ce1(l_ce1), .wr(l_wr), .ba(l_ba), .own(own_q),
    .hit(l_hit), .rd_ok(l_rd_ok), .err_now(l_err_now)
  );

  bdp_port_dec #(.NB(NBANK), .BW(BW), .IS_R(1'b1)) u_dec_r (
    .rst(rst), .ce0_n(r_ce0_n), .ce1(r_ce1), .wr(r_wr), .ba(r_ba), .own(own_q),
    .hit(r_hit), .rd_ok(r_rd_ok), .err_now(r_err_now)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      bdp_bank #(.AW(AW), .DW(DW), .NL(NL)) u_bank (
        .clk(clk), .own(own_q[b]),
        .l_hit(l_hit[b]), .l_wr(l_wr), .l_be(l_be), .l_addr(l_addr), .l_wd(l_wdata),
        .r_hit(r_hit[b]), .r_wr(r_wr), .r_be(r_be), .r_addr(r_addr), .r_wd(r_wdata),
        .q(bank_q[b])
      );
    end
  endgenerate

  bdp_rdport #(.NB(NBANK), .BW(BW), .DW(DW), .NL(NL)) u_rd_l (
    .clk(clk), .rst(rst), .rd_ok(l_rd_ok), .err_now(l_err_now), .ba(l_ba),
    .be(l_be), .oe_n(l_oe_n), .bank_q(bank_q), .rdata(l_rdata), .err(l_err)
  );

  bdp_rdport #(.NB(NBANK), .BW(BW), .DW(DW), .NL(NL)) u_rd_r (
    .clk(clk), .rst(rst), .rd_ok(r_rd_ok), .err_now(r_err_now), .ba(r_ba),
    .be(r_be), .oe_n(r_oe_n), .bank_q(bank_q), .rdata(r_rdata), .err(r_err)
  );
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int DW = 16,
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [NB-1:0] own_q,
  input logic          l_ce0_n,
  input logic          l_ce1,
  input logic          l_wr,
  input logic          l_oe_n,
  input logic [NL-1:0] l_be,
  input logic [BW-1:0] l_ba,
  input logic [DW-1:0] l_rdata,
  input logic          l_err,
  input logic          r_ce0_n,
  input logic          r_ce1,
  input logic          r_wr,
  input logic          r_oe_n,
  input logic [NL-1:0] r_be,
  input logic [BW-1:0] r_ba,
  input logic [DW-1:0] r_rdata,
  input logic          r_err
);
  logic l_act, r_act, l_bad, r_bad;
  assign l_act = !l_ce0_n && l_ce1;
  assign r_act = !r_ce0_n && r_ce1;
  assign l_bad = l_act && own_q[l_ba];
  assign r_bad = r_act && !own_q[r_ba];

  // R6
  l_err_set_chk: assert property (@(posedge clk) disable iff (rst) l_bad |=> l_err);
  // R6
  r_err_set_chk: assert property (@(posedge clk) disable iff (rst) r_bad |=> r_err);
  // R3
  l_err_quiet_chk: assert property (@(posedge clk) disable iff (rst) !l_bad |=> !l_err);
  // R3
  r_err_quiet_chk: assert property (@(posedge clk) disable iff (rst) !r_bad |=> !r_err);
  // R6
  l_err_zero_chk: assert property (@(posedge clk) disable iff (rst) l_err |-> l_rdata == '0);
  // R6
  r_err_zero_chk: assert property (@(posedge clk) disable iff (rst) r_err |-> r_rdata == '0);
  // R7
  l_oe_off_chk: assert property (@(posedge clk) disable iff (rst) l_oe_n |-> l_rdata == '0);
  // R7
  r_oe_off_chk: assert property (@(posedge clk) disable iff (rst) r_oe_n |-> r_rdata == '0);
  // R2
  l_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (l_act && !l_wr && !l_be[0]) |=> l_rdata[7:0] == 8'h00);
  // R2
  r_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (r_act && !r_wr && !r_be[0]) |=> r_rdata[7:0] == 8'h00);
endmodule

bind bank_dpram bdp_chk #(.NB(NBANK), .BW(BW), .DW(DW), .NL(NL)) u_chk (
  .clk(clk), .rst(rst), .own_q(own_q),
  .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_wr(l_wr), .l_oe_n(l_oe_n), .l_be(l_be),
  .l_ba(l_ba), .l_rdata(l_rdata), .l_err(l_err),
  .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_wr(r_wr), .r_oe_n(r_oe_n), .r_be(r_be),
  .r_ba(r_ba), .r_rdata(r_rdata), .r_err(r_err)
);

// File: tb/sim_bank_dpram.sv
module sim_bank_dpram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bank_sel = 4'b1010;
  logic        l_ce0_n = 1'b1, l_ce1 = 1'b0, l_wr = 1'b0, l_oe_n = 1'b0;
  logic [1:0]  l_be = 2'b00, l_ba = 2'd0;
  logic [5:0]  l_addr = '0;
  logic [15:0] l_wdata = '0, l_rdata;
  logic        l_err;
  logic        r_ce0_n = 1'b1, r_ce1 = 1'b0, r_wr = 1'b0, r_oe_n = 1'b0;
  logic [1:0]  r_be = 2'b00, r_ba = 2'd0;
  logic [5:0]  r_addr = '0;
  logic [15:0] r_wdata = '0, r_rdata;
  logic        r_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bank_dpram u0 (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_wr(l_wr), .l_oe_n(l_oe_n), .l_be(l_be),
    .l_ba(l_ba), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_wr(r_wr), .r_oe_n(r_oe_n), .r_be(r_be),
    .r_ba(r_ba), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err)
  );

  typedef struct packed {
    logic        side;
    logic        wr;
    logic [1:0]  ba;
    logic [5:0]  addr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] xd;
    logic        xe;
  } vec_t;

  // bank_sel = 1010: banks 0,2 left; banks 1,3 right
  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 2'd0, 6'd5,  2'b11, 16'h1234, 16'h0000, 1'b0}, // R1
    '{1'b0, 1'b0, 2'd0, 6'd5,  2'b11, 16'h0000, 16'h1234, 1'b0}, // R2
    '{1'b1, 1'b1, 2'd1, 6'd5,  2'b11, 16'hABCD, 16'h0000, 1'b0}, // R10
    '{1'b1, 1'b0, 2'd1, 6'd5,  2'b11, 16'h0000, 16'hABCD, 1'b0}, // R10
    '{1'b0, 1'b0, 2'd1, 6'd5,  2'b11, 16'h0000, 16'h0000, 1'b1}, // R6
    '{1'b0, 1'b1, 2'd1, 6'd5,  2'b11, 16'h5555, 16'h0000, 1'b1}, // R5
    '{1'b1, 1'b0, 2'd1, 6'd5,  2'b11, 16'h0000, 16'hABCD, 1'b0}, // R5
    '{1'b0, 1'b1, 2'd2, 6'd3,  2'b11, 16'h1111, 16'h0000, 1'b0}, // R1
    '{1'b0, 1'b1, 2'd2, 6'd3,  2'b01, 16'h22EE, 16'h0000, 1'b0}, // R1
    '{1'b0, 1'b0, 2'd2, 6'd3,  2'b11, 16'h0000, 16'h11EE, 1'b0}, // R1
    '{1'b0, 1'b1, 2'd2, 6'd3,  2'b10, 16'h77FF, 16'h0000, 1'b0}, // R1
    '{1'b0, 1'b0, 2'd2, 6'd3,  2'b10, 16'h0000, 16'h7700, 1'b0}, // R2
    '{1'b0, 1'b0, 2'd2, 6'd3,  2'b01, 16'h0000, 16'h00EE, 1'b0}, // R2
    '{1'b1, 1'b1, 2'd3, 6'd63, 2'b11, 16'hF00F, 16'h0000, 1'b0}, // R10
    '{1'b1, 1'b0, 2'd3, 6'd63, 2'b11, 16'h0000, 16'hF00F, 1'b0}, // R10
    '{1'b1, 1'b1, 2'd2, 6'd3,  2'b11, 16'h0BAD, 16'h0000, 1'b1}, // R5
    '{1'b0, 1'b0, 2'd2, 6'd3,  2'b11, 16'h0000, 16'h77EE, 1'b0}, // R5
    '{1'b0, 1'b1, 2'd0, 6'd5,  2'b00, 16'hFFFF, 16'h0000, 1'b0}, // R1
    '{1'b0, 1'b0, 2'd0, 6'd5,  2'b11, 16'h0000, 16'h1234, 1'b0}  // R1
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_ce0_n = 1'b1; l_ce1 = 1'b0; l_wr = 1'b0;
    r_ce0_n = 1'b1; r_ce1 = 1'b0; r_wr = 1'b0;
  endtask

  task automatic drv(input logic side, input logic wr, input logic [1:0] ba,
                     input logic [5:0] a, input logic [1:0] be, input logic [15:0] wd);
    if (side == 1'b0) begin
      l_ce0_n = 1'b0; l_ce1 = 1'b1; l_wr = wr; l_ba = ba; l_addr = a; l_be = be; l_wdata = wd;
    end else begin
      r_ce0_n = 1'b0; r_ce1 = 1'b1; r_wr = wr; r_ba = ba; r_addr = a; r_be = be; r_wdata = wd;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 left data after reset", l_rdata, 16'h0);
    chk("R9 left err after reset", {15'h0, l_err}, 16'h0);
    chk("R9 right data after reset", r_rdata, 16'h0);
    chk("R9 right err after reset", {15'h0, r_err}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      idle();
      drv(VT[i].side, VT[i].wr, VT[i].ba, VT[i].addr, VT[i].be, VT[i].wd);
      @(negedge clk);
      if (VT[i].side == 1'b0) begin
        chk($sformatf("R1/R2/R5/R6/R10 vec %0d left data", i), l_rdata, VT[i].xd);
        chk($sformatf("R6 vec %0d left err", i), {15'h0, l_err}, {15'h0, VT[i].xe});
      end else begin
        chk($sformatf("R1/R2/R5/R6/R10 vec %0d right data", i), r_rdata, VT[i].xd);
        chk($sformatf("R6 vec %0d right err", i), {15'h0, r_err}, {15'h0, VT[i].xe});
      end
    end

    // R7: output enable gates the pending read within the cycle
    idle(); drv(1'b0, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0);
    @(negedge clk);
    l_oe_n = 1'b1; #1;
    chk("R7 oe high hides data", l_rdata, 16'h0);
    l_oe_n = 1'b0; #1;
    chk("R7 oe low shows data", l_rdata, 16'h1234);

    // R3: each chip enable alone blocks a write
    idle(); l_ce0_n = 1'b1; l_ce1 = 1'b1; l_wr = 1'b1; l_ba = 2'd0; l_addr = 6'd5;
    l_be = 2'b11; l_wdata = 16'h9999;
    @(negedge clk);
    chk("R3 ce0_n high no err", {15'h0, l_err}, 16'h0);
    l_ce0_n = 1'b0; l_ce1 = 1'b0;
    @(negedge clk);
    chk("R3 ce1 low no data", l_rdata, 16'h0);
    idle(); drv(1'b0, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0);
    @(negedge clk);
    chk("R3 word kept", l_rdata, 16'h1234);

    // R4: select change in same cycle as request -> old owner
    idle(); bank_sel[0] = 1'b1; drv(1'b0, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0);
    @(negedge clk);
    chk("R4 old owner served", l_rdata, 16'h1234);
    chk("R4 old owner no err", {15'h0, l_err}, 16'h0);
    idle(); drv(1'b0, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0); drv(1'b1, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0);
    @(negedge clk);
    chk("R4 left lost bank err", {15'h0, l_err}, 16'h1);
    chk("R4 left lost bank data", l_rdata, 16'h0);
    chk("R4 right gains bank", r_rdata, 16'h1234);

    // R8: concurrent writes then reads on different banks
    idle(); drv(1'b0, 1'b1, 2'd2, 6'd7, 2'b11, 16'h0A0A); drv(1'b1, 1'b1, 2'd0, 6'd7, 2'b11, 16'h0B0B);
    @(negedge clk);
    idle(); drv(1'b0, 1'b0, 2'd2, 6'd7, 2'b11, 16'h0); drv(1'b1, 1'b0, 2'd0, 6'd7, 2'b11, 16'h0);
    @(negedge clk);
    chk("R8 left concurrent", l_rdata, 16'h0A0A);
    chk("R8 right concurrent", r_rdata, 16'h0B0B);

    // R9: access during reset ignored, outputs cleared
    idle(); rst = 1'b1; drv(1'b1, 1'b1, 2'd0, 6'd5, 2'b11, 16'hDEAD);
    @(negedge clk);
    chk("R9 data in reset", r_rdata, 16'h0);
    idle(); rst = 1'b0; drv(1'b1, 1'b0, 2'd0, 6'd5, 2'b11, 16'h0);
    @(negedge clk);
    chk("R9 write in reset ignored", r_rdata, 16'h1234);

    idle();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule